// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the control strobes for one cycle on an external memory bus. An accepted request runs through a fixed sequence. First comes an address phase of one clock, in which a short address latch pulse marks valid address. Next comes a data phase of two clocks, in which the read or write strobe is low. Then one clock passes with every strobe released. Finally a completion pulse lasts one clock. Only requests flagged as external start a cycle. Requests flagged as internal produce no bus activity at all.

The address goes out in one of two bus layouts. In the shared layout, the low 16 address bits travel on the address/data lines during the address phase, and the upper four bits sit on their own pins. In the separate layout, all 20 address bits have dedicated pins and the address/data lines carry data only. A byte-select pin and address bit 0 together tell external memory which lanes take part. A configuration bit picks the pin's role. It is either a high-lane enable covering the whole cycle, or a high-lane write strobe that pulses with the write strobe. The configuration is captured when a request is accepted and holds for that whole cycle.

Top module: `xbus_strobe_gen`

## Requirements
- R1: Out of reset and while idle: addr_strobe=0, rd_n=1, wr_n=1, hb_n=1, ad_oe=0, cyc_done=0, busy=0, and ad_out, addr_hi and addr_lo are all zero.
- R2: An accepted request (req_valid=1 and req_ext=1 while idle, sampled on a rising edge) raises addr_strobe during exactly the next clock, and during no other clock of the cycle.
- R3: A request with req_ext=0 is ignored: no strobe moves, busy stays 0 and cyc_done stays 0.
- R4: For exactly the two clocks after the address clock, rd_n is low for a read (req_write=0) or wr_n is low for a write (req_write=1); the two are never low together.
- R5: After the data phase, one clock passes with all strobes high and addr_strobe low, then cyc_done is high for exactly one clock; busy is high from the address clock through the cyc_done clock.
- R6: A request presented while busy is dropped and not queued; the clock after cyc_done is idle.
- R7: In shared layout (cfg_split=0), addr_hi carries address bits 19:16 through the address and data phases, ad_out carries the low 16 address bits with ad_oe=1 in the address clock, and addr_lo stays 0.
- R8: In separate layout (cfg_split=1), addr_lo carries the low 16 address bits and addr_hi carries bits 19:16 through the address and data phases, and ad_oe is 0 in the address clock.
- R9: During the data phase of a write, ad_oe=1 and ad_out carries the write data; a byte write (req_word=0) copies req_wdata[7:0] onto both lanes. During a read, ad_oe=0.
- R10: Lane encoding: a word request (req_word=1) drives address bit 0 as 0 and activates the high lane; a byte request at an even address drives bit 0 as 0 with the high lane inactive; a byte request at an odd address drives bit 0 as 1 with the high lane active. Bit 0 appears as ad_out[0] (shared) or addr_lo[0] (separate) in the address clock.
- R11: With cfg_hb_enable=1, hb_n is low through the address and data phases whenever the high lane is active, for both reads and writes, and is high otherwise.
- R12: With cfg_hb_enable=0, hb_n is low only in data-phase clocks of writes with the high lane active, together with wr_n, and stays high during reads.
- R13: cfg_split and cfg_hb_enable are captured at acceptance; changing them during a cycle does not affect that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ext | input | 1 | Request targets external memory |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte data in bits 7:0) |
| cfg_split | input | 1 | 1 = separate address pins, 0 = shared address/data |
| cfg_hb_enable | input | 1 | 1 = byte pin is high-lane enable, 0 = high-lane write strobe |
| addr_strobe | output | 1 | Address latch pulse, active high |
| addr_hi | output | 4 | Address bits 19:16 |
| addr_lo | output | 16 | Address bits 15:0 in separate layout |
| ad_out | output | 16 | Value driven on the address/data lines |
| ad_oe | output | 1 | Address/data lines driven by this block |
| hb_n | output | 1 | Shared byte-select pin, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cyc_done | output | 1 | Cycle complete, one clock |
| busy | output | 1 | Cycle in progress |

## Verification
The hardest situations to reach from the ports are a request landing while a cycle is already running and a configuration change in the middle of a cycle. Neither happens when requests arrive one at a time. The bench covers both by raising a fresh external request during the data phase and holding it until the idle clock. In a separate run it flips both configuration inputs right after the address clock. In each case it checks, clock by clock, that the running cycle keeps the values it had at acceptance and that no second address pulse follows.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_DATA = 3'd2,
        PH_TAIL = 3'd3,
        PH_DONE = 3'd4
    } xbs_phase_e;

endpackage

// File: rtl/xbs_seq.sv
module xbs_seq
    import xbs_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int DATA_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ext,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_split,
    input  logic              cfg_hb_enable,
    output xbs_phase_e        phase_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              word_o,
    output logic              write_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              split_o,
    output logic              hb_en_o
);

    localparam int CNT_W = (DATA_CYC > 1) ? $clog2(DATA_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_CYC - 1);

    typedef struct packed {
        xbs_phase_e        ph;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              word;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic              split;
        logic              hb_en;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid && req_ext) begin
                    st_d.ph    = PH_ADDR;
                    st_d.addr  = req_addr;
                    st_d.word  = req_word;
                    st_d.write = req_write;
                    st_d.wdata = req_wdata;
                    st_d.split = cfg_split;
                    st_d.hb_en = cfg_hb_enable;
                end
            end
            PH_ADDR: begin
                st_d.ph  = PH_DATA;
                st_d.cnt = '0;
            end
            PH_DATA: begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.ph = PH_TAIL;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_TAIL: st_d.ph = PH_DONE;
            PH_DONE: st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.ph;
    assign addr_o  = st_q.addr;
    assign word_o  = st_q.word;
    assign write_o = st_q.write;
    assign wdata_o = st_q.wdata;
    assign split_o = st_q.split;
    assign hb_en_o = st_q.hb_en;

    // R6: a running cycle never restarts from a new request
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph inside {PH_ADDR, PH_DATA, PH_TAIL}) |=> (st_q.ph != PH_ADDR));

    // R13: captured request and configuration hold while the cycle runs
    p_hold_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph inside {PH_ADDR, PH_DATA, PH_TAIL}) |=>
            ($stable(st_q.addr) && $stable(st_q.split) && $stable(st_q.hb_en)
             && $stable(st_q.write) && $stable(st_q.word)));

    // R5: the completion phase lasts a single clock
    p_done_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_DONE) |=> (st_q.ph == PH_IDLE));

endmodule

// File: rtl/xbs_lane.sv
module xbs_lane #(
    parameter int DATA_W = 16
) (
    input  logic              addr_lsb,
    input  logic              word,
    input  logic [DATA_W-1:0] wdata,
    output logic              a0_out,
    output logic              hi_active,
    output logic [DATA_W-1:0] lane_data
);

    localparam int BYTE_W = DATA_W / 2;

    always_comb begin
        if (word) begin
            a0_out    = 1'b0;
            hi_active = 1'b1;
            lane_data = wdata;
        end else begin
            a0_out    = addr_lsb;
            hi_active = addr_lsb;
            lane_data = {wdata[BYTE_W-1:0], wdata[BYTE_W-1:0]};
        end
    end

endmodule

// File: rtl/xbs_drive.sv
module xbs_drive
    import xbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  xbs_phase_e          phase,
    input  logic [ADDR_W-1:1]   addr_up,
    input  logic                write,
    input  logic                split,
    input  logic                hb_en,
    input  logic                a0_out,
    input  logic                hi_active,
    input  logic [DATA_W-1:0]   lane_data,
    output logic                addr_strobe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]   addr_lo,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    output logic                hb_n,
    output logic                rd_n,
    output logic                wr_n,
    output logic                cyc_done,
    output logic                busy
);

    logic              in_addr, in_data, in_span;
    logic [DATA_W-1:0] low_addr;

    always_comb begin
        in_addr  = (phase == PH_ADDR);
        in_data  = (phase == PH_DATA);
        in_span  = in_addr || in_data;
        low_addr = {addr_up[DATA_W-1:1], a0_out};

        addr_strobe = in_addr;
        rd_n        = !(in_data && !write);
        wr_n        = !(in_data && write);
        cyc_done    = (phase == PH_DONE);
        busy        = (phase != PH_IDLE);

        addr_hi = in_span ? addr_up[ADDR_W-1:DATA_W] : '0;
        addr_lo = (in_span && split) ? low_addr : '0;

        ad_oe  = 1'b0;
        ad_out = '0;
        if (in_addr && !split) begin
            ad_oe  = 1'b1;
            ad_out = low_addr;
        end else if (in_data && write) begin
            ad_oe  = 1'b1;
            ad_out = lane_data;
        end

        if (hb_en) begin
            hb_n = !(in_span && hi_active);
        end else begin
            hb_n = !(in_data && write && hi_active);
        end
    end

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbs_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int DATA_CYC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_ext,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_word,
    input  logic                     req_write,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     cfg_split,
    input  logic                     cfg_hb_enable,
    output logic                     addr_strobe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        addr_lo,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     hb_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     cyc_done,
    output logic                     busy
);

    xbs_phase_e        phase;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_word, cur_write, cur_split, cur_hb_en;
    logic [DATA_W-1:0] cur_wdata;
    logic              a0_out, hi_active;
    logic [DATA_W-1:0] lane_data;

    xbs_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .DATA_CYC(DATA_CYC)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ext      (req_ext),
        .req_addr     (req_addr),
        .req_word     (req_word),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .cfg_split    (cfg_split),
        .cfg_hb_enable(cfg_hb_enable),
        .phase_o      (phase),
        .addr_o       (cur_addr),
        .word_o       (cur_word),
        .write_o      (cur_write),
        .wdata_o      (cur_wdata),
        .split_o      (cur_split),
        .hb_en_o      (cur_hb_en)
    );

    xbs_lane #(
        .DATA_W(DATA_W)
    ) i_lane (
        .addr_lsb (cur_addr[0]),
        .word     (cur_word),
        .wdata    (cur_wdata),
        .a0_out   (a0_out),
        .hi_active(hi_active),
        .lane_data(lane_data)
    );

    xbs_drive #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_drive (
        .phase      (phase),
        .addr_up    (cur_addr[ADDR_W-1:1]),
        .write      (cur_write),
        .split      (cur_split),
        .hb_en      (cur_hb_en),
        .a0_out     (a0_out),
        .hi_active  (hi_active),
        .lane_data  (lane_data),
        .addr_strobe(addr_strobe),
        .addr_hi    (addr_hi),
        .addr_lo    (addr_lo),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .hb_n       (hb_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .cyc_done   (cyc_done),
        .busy       (busy)
    );

    // R2: the latch pulse is one clock wide
    p_strobe_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> !addr_strobe);

    // R4: the latch pulse is followed by a data strobe
    p_strobe_then_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> (!rd_n || !wr_n));

    // R4: read and write strobes are exclusive
    p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R5: completion pulse is one clock wide
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    // R12: in write-strobe role the byte pin moves only with wr_n
    p_hb_with_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_hb_en && !hb_n) |-> !wr_n);

    // R11: the byte pin is released whenever no cycle runs
    p_hb_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> hb_n);

endmodule

// File: tb/test_xbus_strobe_gen.sv
module test_xbus_strobe_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ext, req_word, req_write;
    logic [19:0] req_addr;
    logic [15:0] req_wdata;
    logic        cfg_split, cfg_hb_enable;
    logic        addr_strobe, ad_oe, hb_n, rd_n, wr_n, cyc_done, busy;
    logic [3:0]  addr_hi;
    logic [15:0] addr_lo, ad_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_strobe_gen i_xbus_strobe_gen (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ext(req_ext), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .cfg_split(cfg_split), .cfg_hb_enable(cfg_hb_enable),
        .addr_strobe(addr_strobe), .addr_hi(addr_hi), .addr_lo(addr_lo),
        .ad_out(ad_out), .ad_oe(ad_oe), .hb_n(hb_n), .rd_n(rd_n), .wr_n(wr_n),
        .cyc_done(cyc_done), .busy(busy)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(tag, "addr_strobe", addr_strobe, 0);
        chk(tag, "rd_n", rd_n, 1);
        chk(tag, "wr_n", wr_n, 1);
        chk(tag, "hb_n", hb_n, 1);
        chk(tag, "ad_oe", ad_oe, 0);
        chk(tag, "ad_out", ad_out, 0);
        chk(tag, "addr_hi", addr_hi, 0);
        chk(tag, "addr_lo", addr_lo, 0);
        chk(tag, "cyc_done", cyc_done, 0);
        chk(tag, "busy", busy, 0);
    endtask

    // runs one full cycle and checks every clock of it against the requirements
    task automatic run_cycle(input logic [19:0] addr, input logic word, input logic write,
                             input logic [15:0] wdata, input logic split, input logic hben,
                             input bit poke_busy, input bit flip_cfg);
        logic        hi, a0;
        logic [15:0] aout, dout;
        @(negedge clk);
        req_valid = 1; req_ext = 1; req_addr = addr; req_word = word;
        req_write = write; req_wdata = wdata; cfg_split = split; cfg_hb_enable = hben;
        hi   = word || addr[0];
        a0   = word ? 1'b0 : addr[0];
        aout = {addr[15:1], a0};
        dout = word ? wdata : {wdata[7:0], wdata[7:0]};
        for (int p = 0; p < 5; p++) begin
            @(negedge clk);
            if (p == 0) begin
                req_valid = 0;
                if (flip_cfg) begin
                    cfg_split = !split; cfg_hb_enable = !hben;
                end
            end
            if (poke_busy && p == 1) begin
                req_valid = 1; req_ext = 1; req_addr = 20'h5_5555;
            end
            if (poke_busy && p == 3) req_valid = 0;
            chk("R2", "addr_strobe", addr_strobe, p == 0);
            chk("R4", "rd_n", rd_n, !((p == 1 || p == 2) && !write));
            chk("R4", "wr_n", wr_n, !((p == 1 || p == 2) && write));
            if (hben)
                chk(flip_cfg ? "R13" : "R11", "hb_n", hb_n, !(hi && p <= 2));
            else
                chk(flip_cfg ? "R13" : "R12", "hb_n", hb_n, !(hi && write && (p == 1 || p == 2)));
            chk("R7", "addr_hi", addr_hi, (p <= 2) ? addr[19:16] : 4'h0);
            chk(split ? "R8" : "R7", "addr_lo", addr_lo, (split && p <= 2) ? aout : 16'h0);
            if (p == 0) begin
                chk(split ? "R8" : "R7", "ad_oe", ad_oe, !split);
                chk("R10", "ad_out", ad_out, split ? 16'h0 : aout);
            end else if (p <= 2) begin
                chk("R9", "ad_oe", ad_oe, write);
                chk("R9", "ad_out", ad_out, write ? dout : 16'h0);
            end else begin
                chk("R5", "ad_oe", ad_oe, 0);
            end
            chk("R5", "cyc_done", cyc_done, p == 4);
            chk("R5", "busy", busy, 1);
        end
        @(negedge clk);
        check_idle(poke_busy ? "R6" : "R5");
        cfg_split = split; cfg_hb_enable = hben;
    endtask

    task automatic test_reset;
        rst_n = 0; req_valid = 0; req_ext = 0; req_addr = '0; req_word = 0;
        req_write = 0; req_wdata = '0; cfg_split = 0; cfg_hb_enable = 1;
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1;
        @(negedge clk);
        check_idle("R1");
    endtask

    task automatic test_internal;
        @(negedge clk);
        req_valid = 1; req_ext = 0; req_addr = 20'hA_1235; req_write = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_idle("R3");
        end
        req_valid = 0;
    endtask

    task automatic test_lane_codes;
        // R10: word at odd address forces bit 0 low, high lane active
        run_cycle(20'h3_4567, 1, 0, 16'h0, 0, 1, 0, 0);
        run_cycle(20'h3_4566, 0, 0, 16'h0, 0, 1, 0, 0);
        run_cycle(20'h3_4567, 0, 0, 16'h0, 1, 1, 0, 0);
    endtask

    task automatic test_writes;
        run_cycle(20'hF_2000, 1, 1, 16'hBEEF, 0, 0, 0, 0);
        run_cycle(20'h1_0001, 0, 1, 16'h12C3, 1, 0, 0, 0);
        run_cycle(20'h1_0002, 0, 1, 16'h12C3, 0, 0, 0, 0);
        run_cycle(20'h8_00FF, 0, 0, 16'h0, 0, 0, 0, 0);
        run_cycle(20'h2_ABCD, 0, 1, 16'h77A5, 1, 1, 0, 0);
    endtask

    task automatic test_busy_poke;
        run_cycle(20'h4_1000, 1, 0, 16'h0, 1, 1, 1, 0);
    endtask

    task automatic test_cfg_flip;
        run_cycle(20'h6_0031, 0, 1, 16'h00A9, 0, 0, 0, 1);
        run_cycle(20'h6_0031, 0, 0, 16'h0, 1, 1, 0, 1);
    endtask

    initial begin
        test_reset();
        test_internal();
        test_lane_codes();
        test_writes();
        test_busy_poke();
        test_cfg_flip();
        test_internal();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule